// File: doc/BRIEF.md
# Interlocked Multiplexed-Bus Read Master

This block is the requesting side of a shared bus on which address and data travel over the same lines and every transfer is paced by a fully interlocked request/acknowledge exchange. It takes a read command made of a start address and a word count. It asks an arbiter for the bus and, once granted, places the address on the shared lines and raises its read strobe. It then collects one or more data words from the responding device and hands the bus back.

Every exchange is four-phase. Each edge the master produces waits for the opposite edge from the other side. The address exchange happens once per command. A multi-word read repeats only the data exchange, and the bus request is held until the last word has been acknowledged and released. All handshake inputs come from outside the clock domain, so each is resynchronised through two flops before the state machine acts on it.

Received words appear on a local port with a one-cycle valid strobe and their index within the block. A one-cycle done pulse marks the cycle in which the bus request is withdrawn.

Top module: `mbus_rd_master`

## Requirements
- R1: While reset is held, `bus_req`, `ad_oe`, `rd_strb`, `mst_ack`, `done` and `word_valid` are all low and `ad_out` is zero. After release the block is idle with `cmd_ready` high.
- R2: A command (`cmd_valid` high for one cycle) is taken only while `cmd_ready` is high. A `cmd_valid` pulse while a read is in progress has no effect on that read, and no second read follows from it.
- R3: Accepting a command raises `bus_req` on the next clock. `ad_oe`, `rd_strb` and `mst_ack` stay low until the synchronised grant has been seen, and none of them is ever high while `bus_req` is low.
- R4: After the grant, `ad_oe` rises with `ad_out` equal to the command address for exactly one cycle before `rd_strb` rises. Both then hold, with the address unchanged, until the synchronised slave acknowledge is high.
- R5: Once the slave acknowledge is seen, `rd_strb` and `ad_oe` fall in the same cycle. The data phase does not begin until the synchronised slave acknowledge is seen low again.
- R6: When synchronised `dat_rdy` is high in the data phase, `ad_in` is captured. On the next cycle `word_valid` pulses for one cycle with that word on `word_data` and its zero-based index on `word_idx`, and `mst_ack` rises in that same cycle.
- R7: `mst_ack` stays high until synchronised `dat_rdy` is seen low, and it never overlaps `ad_oe`.
- R8: A `cmd_cnt` value of N yields exactly N+1 data exchanges with indices 0 to N, and no further address phase. `bus_req` stays high across all of them.
- R9: After the last word's `mst_ack` falls, `bus_req` drops and `done` is high for exactly that one cycle. On the next cycle the block is idle again.
- R10: Every handshake input (`bus_gnt`, `slv_ack`, `dat_rdy`) passes through two flops. A change of one of them seen before clock edge k affects the outputs after edge k+2, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Read command strobe |
| cmd_addr | input | DW | Start address of the read |
| cmd_cnt | input | CW | Number of words minus one |
| cmd_ready | output | 1 | High while idle; a command is taken only then |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter (asynchronous) |
| ad_oe | output | 1 | Output enable for the shared address/data lines |
| ad_out | output | DW | Value driven onto the shared lines (address) |
| ad_in | input | DW | Value read back from the shared lines (data) |
| rd_strb | output | 1 | Read strobe |
| slv_ack | input | 1 | Slave acknowledge of the address (asynchronous) |
| dat_rdy | input | 1 | Slave data-ready strobe (asynchronous) |
| mst_ack | output | 1 | Master acknowledge of a data word |
| word_valid | output | 1 | One-cycle strobe for a received word |
| word_data | output | DW | Received word |
| word_idx | output | CW | Index of the received word within the block |
| done | output | 1 | One-cycle pulse when the bus request is withdrawn |

## Verification
The bound checker watches the ordering rules on every cycle. It confirms that no bus driver is active without a request, that the address leads the strobe and stays stable, that strobe and address fall together, that acknowledge and address drive never overlap, and that the valid and done strobes last one cycle. What the checker cannot see is the exact latency through the synchronisers, the word count and index sequence, the data values, and whether a command issued while busy is really ignored. Those rest on the bench's reference model. The model tracks every output on every clock while a responding device and an arbiter in the bench react with varied delays, including none.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_REQ   = 3'd1,
    S_ADDR  = 3'd2,
    S_STRB  = 3'd3,
    S_DROP  = 3'd4,
    S_DWAIT = 3'd5,
    S_DACK  = 3'd6,
    S_REL   = 3'd7
  } mbr_state_e;
endpackage

// File: rtl/mbr_rst_sync.sv
module mbr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic r1_q, r2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_q <= 1'b0;
      r2_q <= 1'b0;
    end else begin
      r1_q <= 1'b1;
      r2_q <= r1_q;
    end
  end

  assign srst_n = r2_q;
endmodule

// File: rtl/mbr_sync.sv
module mbr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
    end else begin
      pipe_q[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/mbr_ctrl.sv
module mbr_ctrl
  import mbr_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [CW-1:0] cmd_cnt,
  input  logic          gnt_s,
  input  logic          ack_s,
  input  logic          drdy_s,
  output logic          load,
  output logic          cap,
  output logic [CW-1:0] cap_idx,
  output logic          cmd_ready,
  output logic          bus_req,
  output logic          ad_oe,
  output logic          rd_strb,
  output logic          mst_ack,
  output logic          done
);
  mbr_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] last_q, last_d;
  logic          fin_q, fin_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    last_d  = last_q;
    fin_d   = fin_q;
    load    = 1'b0;
    cap     = 1'b0;
    unique case (state_q)
      S_IDLE: if (cmd_valid) begin
        load    = 1'b1;
        last_d  = cmd_cnt;
        cnt_d   = '0;
        fin_d   = 1'b0;
        state_d = S_REQ;
      end
      S_REQ:   if (gnt_s)  state_d = S_ADDR;
      S_ADDR:  state_d = S_STRB;
      S_STRB:  if (ack_s)  state_d = S_DROP;
      S_DROP:  if (!ack_s) state_d = S_DWAIT;
      S_DWAIT: if (drdy_s) begin
        cap     = 1'b1;
        fin_d   = (cnt_q == last_q);
        cnt_d   = cnt_q + 1'b1;
        state_d = S_DACK;
      end
      S_DACK:  if (!drdy_s) state_d = fin_q ? S_REL : S_DWAIT;
      S_REL:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      last_q  <= '0;
      fin_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load || cap) begin
        cnt_q <= cnt_d;
        fin_q <= fin_d;
      end
      if (load) last_q <= last_d;
    end
  end

  assign cap_idx   = cnt_q;
  assign cmd_ready = (state_q == S_IDLE);
  assign bus_req   = (state_q != S_IDLE) && (state_q != S_REL);
  assign ad_oe     = (state_q == S_ADDR) || (state_q == S_STRB);
  assign rd_strb   = (state_q == S_STRB);
  assign mst_ack   = (state_q == S_DACK);
  assign done      = (state_q == S_REL);
endmodule

// File: rtl/mbr_datapath.sv
module mbr_datapath #(
  parameter int DW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] cmd_addr,
  input  logic          cap,
  input  logic [CW-1:0] cap_idx,
  input  logic [DW-1:0] ad_in,
  input  logic          ad_oe,
  output logic [DW-1:0] ad_out,
  output logic          word_valid,
  output logic [DW-1:0] word_data,
  output logic [CW-1:0] word_idx
);
  logic [DW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [CW-1:0] idx_q;
  logic          valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      data_q  <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= cap;
      if (load) addr_q <= cmd_addr;
      if (cap) begin
        data_q <= ad_in;
        idx_q  <= cap_idx;
      end
    end
  end

  assign ad_out     = ad_oe ? addr_q : '0;
  assign word_valid = valid_q;
  assign word_data  = data_q;
  assign word_idx   = idx_q;
endmodule

// File: rtl/mbus_rd_master.sv
module mbus_rd_master #(
  parameter int DW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [DW-1:0] cmd_addr,
  input  logic [CW-1:0] cmd_cnt,
  output logic          cmd_ready,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          ad_oe,
  output logic [DW-1:0] ad_out,
  input  logic [DW-1:0] ad_in,
  output logic          rd_strb,
  input  logic          slv_ack,
  input  logic          dat_rdy,
  output logic          mst_ack,
  output logic          word_valid,
  output logic [DW-1:0] word_data,
  output logic [CW-1:0] word_idx,
  output logic          done
);
  localparam int NHS = 3;

  logic           srst_n;
  logic [NHS-1:0] hs_raw, hs_s;
  logic           load, cap;
  logic [CW-1:0]  cap_idx;

  assign hs_raw = {bus_gnt, slv_ack, dat_rdy};

  mbr_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  mbr_sync #(.W(NHS), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .d     (hs_raw),
    .q     (hs_s)
  );

  mbr_ctrl #(.CW(CW)) u_ctrl (
    .clk       (clk),
    .rst_n     (srst_n),
    .cmd_valid (cmd_valid),
    .cmd_cnt   (cmd_cnt),
    .gnt_s     (hs_s[2]),
    .ack_s     (hs_s[1]),
    .drdy_s    (hs_s[0]),
    .load      (load),
    .cap       (cap),
    .cap_idx   (cap_idx),
    .cmd_ready (cmd_ready),
    .bus_req   (bus_req),
    .ad_oe     (ad_oe),
    .rd_strb   (rd_strb),
    .mst_ack   (mst_ack),
    .done      (done)
  );

  mbr_datapath #(.DW(DW), .CW(CW)) u_dp (
    .clk        (clk),
    .rst_n      (srst_n),
    .load       (load),
    .cmd_addr   (cmd_addr),
    .cap        (cap),
    .cap_idx    (cap_idx),
    .ad_in      (ad_in),
    .ad_oe      (ad_oe),
    .ad_out     (ad_out),
    .word_valid (word_valid),
    .word_data  (word_data),
    .word_idx   (word_idx)
  );
endmodule

// File: rtl/mbr_chk.sv
module mbr_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          bus_req,
  input logic          ad_oe,
  input logic [DW-1:0] ad_out,
  input logic          rd_strb,
  input logic          mst_ack,
  input logic          word_valid,
  input logic          done
);
  a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!bus_req && !ad_oe && !mst_ack));

  a_r3_drive_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe || rd_strb || mst_ack) |-> bus_req);

  a_r4_addr_leads_strb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_strb) |-> ($past(ad_oe) && ad_oe));

  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && $past(ad_oe)) |-> $stable(ad_out));

  a_r5_release_together: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_strb) |-> (!ad_oe && bus_req));

  a_r6_valid_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> mst_ack);

  a_r6_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  a_r7_ack_not_with_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mst_ack |-> !ad_oe);

  a_r8_req_held_between_words: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mst_ack) |-> (bus_req || done));

  a_r9_done_released: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);

  a_r9_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmd_ready));
endmodule

bind mbus_rd_master mbr_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_ready  (cmd_ready),
  .bus_req    (bus_req),
  .ad_oe      (ad_oe),
  .ad_out     (ad_out),
  .rd_strb    (rd_strb),
  .mst_ack    (mst_ack),
  .word_valid (word_valid),
  .done       (done)
);

// File: tb/tb_mbus_rd_master.sv
module tb_mbus_rd_master;
  localparam int DW = 16;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [DW-1:0] cmd_addr;
  logic [CW-1:0] cmd_cnt;
  logic          cmd_ready, bus_req, bus_gnt, ad_oe, rd_strb, slv_ack, dat_rdy;
  logic          mst_ack, word_valid, done;
  logic [DW-1:0] ad_out, ad_in, word_data;
  logic [CW-1:0] word_idx;

  int checks = 0;
  int fails  = 0;
  int nwords = 0;
  int ndone  = 0;
  int gnt_dly = 1;
  bit finished = 0;

  always #2 clk = ~clk;

  mbus_rd_master #(.DW(DW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_cnt(cmd_cnt), .cmd_ready(cmd_ready), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .ad_oe(ad_oe), .ad_out(ad_out), .ad_in(ad_in), .rd_strb(rd_strb),
    .slv_ack(slv_ack), .dat_rdy(dat_rdy), .mst_ack(mst_ack),
    .word_valid(word_valid), .word_data(word_data), .word_idx(word_idx), .done(done)
  );

  function automatic logic [DW-1:0] wordval(logic [DW-1:0] a, int i);
    return a ^ DW'((i + 1) * 16'h0101);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model: phase number plus delayed copies of the inputs
  int            ph;
  int            mcnt, mlast;
  logic [DW-1:0] maddr;
  logic          mr1, mr2;
  logic [2:0]    ms1, ms2;
  logic          ewv;
  int            eidx;
  logic [DW-1:0] edata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr1 <= 0; mr2 <= 0; ph <= 0; ms1 <= 0; ms2 <= 0; ewv <= 0;
    end else begin
      mr1 <= 1'b1;
      mr2 <= mr1;
      if (!mr2) begin
        ph <= 0; ms1 <= 0; ms2 <= 0; ewv <= 0;
      end else begin
        ms1 <= {bus_gnt, slv_ack, dat_rdy};
        ms2 <= ms1;
        ewv <= 1'b0;
        case (ph)
          0: if (cmd_valid) begin
               ph <= 1; maddr <= cmd_addr; mlast <= int'(cmd_cnt); mcnt <= 0;
             end
          1: if (ms2[2]) ph <= 2;
          2: ph <= 3;
          3: if (ms2[1]) ph <= 4;
          4: if (!ms2[1]) ph <= 5;
          5: if (ms2[0]) begin
               ph <= 6; ewv <= 1'b1; eidx <= mcnt;
               edata <= wordval(maddr, mcnt); mcnt <= mcnt + 1;
             end
          6: if (!ms2[0]) ph <= (mcnt > mlast) ? 7 : 5;
          default: ph <= 0;
        endcase
      end
    end
  end

  // Compare every output against the model on each falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cmd_ready == (ph == 0), "R2", "cmd_ready", cmd_ready, ph == 0);
      chk(bus_req == (ph >= 1 && ph <= 6), "R3 R10", "bus_req", bus_req, ph >= 1 && ph <= 6);
      chk(ad_oe == (ph == 2 || ph == 3), "R4 R10", "ad_oe", ad_oe, ph == 2 || ph == 3);
      chk(ad_out == ((ph == 2 || ph == 3) ? maddr : '0), "R4", "ad_out", ad_out,
          (ph == 2 || ph == 3) ? maddr : 0);
      chk(rd_strb == (ph == 3), "R4 R5", "rd_strb", rd_strb, ph == 3);
      chk(mst_ack == (ph == 6), "R7 R10", "mst_ack", mst_ack, ph == 6);
      chk(done == (ph == 7), "R9", "done", done, ph == 7);
      chk(word_valid == ewv, "R6", "word_valid", word_valid, ewv);
      if (ewv) begin
        chk(word_data == edata, "R6", "word_data", word_data, edata);
        chk(int'(word_idx) == eidx, "R8", "word_idx", word_idx, eidx);
      end
      if (word_valid) nwords++;
      if (done) ndone++;
    end
  end

  // Arbiter: grants after gnt_dly falling edges, withdraws when request drops
  initial begin
    bus_gnt = 1'b0;
    forever begin
      @(negedge clk);
      if (bus_req && !bus_gnt) begin
        repeat (gnt_dly) @(negedge clk);
        bus_gnt = 1'b1;
      end else if (!bus_req && bus_gnt) begin
        bus_gnt = 1'b0;
      end
    end
  end

  task automatic slave(int nw, int d1, int d2, int d3, logic [DW-1:0] exp_addr);
    logic [DW-1:0] sa;
    do @(negedge clk); while (!rd_strb);
    sa = ad_out;
    chk(ad_oe && sa == exp_addr, "R4", "address seen with strobe", sa, exp_addr);
    repeat (d1) @(negedge clk);
    slv_ack = 1'b1;
    do @(negedge clk); while (rd_strb);
    repeat (d2) @(negedge clk);
    slv_ack = 1'b0;
    for (int i = 0; i < nw; i++) begin
      repeat (d3) @(negedge clk);
      ad_in = wordval(sa, i);
      dat_rdy = 1'b1;
      do @(negedge clk); while (!mst_ack);
      dat_rdy = 1'b0;
      ad_in = 16'h5A5A;
      do @(negedge clk); while (mst_ack);
    end
  endtask

  task automatic run_read(logic [DW-1:0] a, int n, int gd, int d1, int d2, int d3, bit inject);
    int w0, dn0;
    gnt_dly = gd;
    w0 = nwords;
    dn0 = ndone;
    fork
      begin
        @(negedge clk);
        chk(cmd_ready, "R2", "ready before command", cmd_ready, 1);
        cmd_valid = 1'b1; cmd_addr = a; cmd_cnt = CW'(n);
        @(negedge clk);
        cmd_valid = 1'b0;
      end
      slave(n + 1, d1, d2, d3, a);
      begin
        if (inject) begin
          repeat (5) @(negedge clk);
          cmd_valid = 1'b1; cmd_addr = 16'hBEEF; cmd_cnt = CW'(5);
          @(negedge clk);
          cmd_valid = 1'b0;
        end
      end
    join
    repeat (12) @(negedge clk);
    chk(nwords - w0 == n + 1, "R8", "words per command", nwords - w0, n + 1);
    chk(ndone - dn0 == 1, "R9", "done pulses per command", ndone - dn0, 1);
    chk(cmd_ready && !bus_req, "R2", "idle after read (busy command ignored)",
        {cmd_ready, bus_req}, 2);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_addr = '0; cmd_cnt = '0;
    slv_ack = 1'b0; dat_rdy = 1'b0; ad_in = '0;
    repeat (4) @(negedge clk);
    chk({bus_req, ad_oe, rd_strb, mst_ack, done, word_valid} == 6'b0, "R1",
        "outputs in reset", {bus_req, ad_oe, rd_strb, mst_ack, done, word_valid}, 0);
    chk(ad_out == '0, "R1", "ad_out in reset", ad_out, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cmd_ready, "R1", "idle after reset", cmd_ready, 1);

    run_read(16'h1234, 0, 1, 1, 1, 1, 1'b0);   // single word
    run_read(16'h00F0, 3, 0, 0, 0, 0, 1'b0);   // zero-delay responder
    run_read(16'hA5C3, 2, 3, 2, 4, 1, 1'b1);   // command while busy must be ignored
    run_read(16'h7FFE, 7, 5, 6, 2, 5, 1'b0);   // long block, slow responder
    run_read(16'hFFFF, 15, 0, 0, 1, 0, 1'b0);  // largest count

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R9 watchdog: actual=hung expected=all reads completed");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule